// File: doc/BRIEF.md
# Field-Gated Six-Channel Timer Bank

The block holds six independent up-counting timer channels behind one register decoder. Channels 0 to 2 are 16 bits wide and channels 3 to 5 are 32 bits wide. Each channel counts a selectable source: the system clock, an external pixel or line tick, or the system clock divided by a prescaler. Each one compares its count against a programmable limit, records target and wrap events in a status word that clears when read, and can raise an interrupt on either event.

A field-timing generator counts line ticks and drives a gate that is high during visible lines and low during vertical blanking. The falling gate edge raises a blanking interrupt. Channels with gating enabled react to the gate edges: they start, stop or restart, or start once and then ignore the gate. The channel interrupts and the blanking interrupt are merged onto fixed bits of a 17-bit vector, where software reads them as one-cycle pulses.

Top module: `field_timer_bank`

## Requirements
- R1: A word-aligned access (address bits 1:0 zero) whose address bits 15:4 equal 0x110, 0x111, 0x112, 0x148, 0x149 or 0x14A selects channel 0 to 5. Address bits 3:2 select the count (0, read only), the mode/status word (1, write mode, read status) or the compare value (2). Any other access reads as zero one cycle later and changes no channel state.
- R2: Read data is registered and appears on the clock after the read. Channels 0 to 2 keep and return only the low 16 bits of written data, and channels 3 to 5 keep all 32 bits.
- R3: A mode write always halts the channel. When mode bit 6 is set and mode bits 2:0 are not 111, the write instead restarts the channel from count 0. A halted channel holds its count, and a running channel adds one per source tick.
- R4: With mode bit 8 set, channel 0 counts pixel ticks and channels 1 and 3 count line ticks. Otherwise a channel counts system clocks, and no other tick input affects it.
- R5: On channel 2, mode bit 9 divides the clock by 8. On channels 4 and 5, mode bits 14:13 = 0,1,2,3 divide the clock by 1, 8, 16 or 256. The divider restarts together with the channel.
- R6: When a counting tick brings the count to the compare value (0 stands for 2^width), status bit 11 is set. With mode bit 3 set the count returns to 0. Otherwise it keeps counting.
- R7: A tick past the all-ones count wraps the count to 0 and sets status bit 12.
- R8: A status read returns the status and clears it. An event in the same cycle as the read stays set for the next read.
- R9: Mode bit 4 (target) and mode bit 5 (wrap) enable a one-cycle interrupt pulse, visible on the clock after the event. The pulse appears on vector bit 4, 5, 6, 14, 15 or 16 for channels 0 to 5.
- R10: The gate starts high with line count 0. On the line tick that brings the count to the visible count, the gate falls and vector bit 0 pulses for one cycle. On the line tick that reaches the total count, the gate rises and the count restarts at 0, with no interrupt.
- R11: A channel with mode bits 6 and 0 set reacts to gate edges one clock after the edge, and all channels react on the same clock. Mode bits 2:1 select the reaction. 0: rise restarts and fall halts. 1: rise restarts. 2: rise halts and fall restarts. 3: rise restarts and clears mode bit 0, so later edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pixel_tick | input | 1 | One-cycle pixel count enable |
| line_tick | input | 1 | One-cycle line count enable |
| visible_lines | input | LINE_W | Line count at which blanking begins |
| total_lines | input | LINE_W | Line count at which a field ends |
| irq_vec | output | 17 | Interrupt pulse vector |

## Verification
The hardest situation to reach from the ports is a status read that lands in the same clock as a target event, because the read clear and the event set then collide in one register. The stimulus starts a system-clock channel with a small compare value and issues the status read exactly on the target edge, counting edges from the starting write. It then reads twice more to see the flag survive once and then clear. The gate modes are driven with directed line pulses against small visible and total counts, so that every channel's restart or halt clock can be predicted exactly. Constrained random traffic covers compare read-back across channels and writes to undecoded addresses.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  localparam int NUM_CH = 6;
  localparam int MODE_W = 16;
  localparam int STS_W  = 16;
  localparam int IRQ_W  = 17;
  localparam int VBL_BIT = 0;

  // mode word fields
  localparam int MB_GATE_EN = 0;
  localparam int MB_LOOP    = 3;
  localparam int MB_IRQ_TGT = 4;
  localparam int MB_IRQ_OVF = 5;
  localparam int MB_RUN     = 6;
  localparam int MB_SRC     = 8;
  localparam int MB_DIV8    = 9;
  localparam int MB_PRE_LO  = 13;

  // status word fields
  localparam int SB_TGT = 11;
  localparam int SB_OVF = 12;

  // register select (address bits 3:2)
  localparam logic [1:0] SEL_COUNT = 2'd0;
  localparam logic [1:0] SEL_MODE  = 2'd1;
  localparam logic [1:0] SEL_CMP   = 2'd2;

  typedef enum logic [1:0] {
    GM_RUN_WHILE_HIGH = 2'd0,
    GM_RESTART_ON_RISE = 2'd1,
    GM_RUN_WHILE_LOW  = 2'd2,
    GM_ONE_SHOT_RISE  = 2'd3
  } gate_mode_e;

  function automatic int ch_width(input int idx);
    return (idx < 3) ? 16 : 32;
  endfunction

  function automatic logic [15:0] ch_base(input int idx);
    case (idx)
      0: return 16'h1100;
      1: return 16'h1110;
      2: return 16'h1120;
      3: return 16'h1480;
      4: return 16'h1490;
      default: return 16'h14A0;
    endcase
  endfunction

  function automatic int ch_irq_bit(input int idx);
    case (idx)
      0: return 4;
      1: return 5;
      2: return 6;
      3: return 14;
      4: return 15;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/ftb_field_gate.sv
module ftb_field_gate #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] visible_lines,
  input  logic [LINE_W-1:0] total_lines,
  output logic              gate_o,
  output logic              rise_o,
  output logic              fall_o
);

  logic [LINE_W-1:0] line_q, line_n;
  logic [LINE_W-1:0] line_inc;
  logic              gate_q, gate_n;
  logic              rise_q, rise_n;
  logic              fall_q, fall_n;

  assign line_inc = line_q + 1'b1;

  always_comb begin
    line_n = line_q;
    gate_n = gate_q;
    rise_n = 1'b0;
    fall_n = 1'b0;
    if (line_tick) begin
      line_n = line_inc;
      if (gate_q) begin
        if (line_inc >= visible_lines) begin
          gate_n = 1'b0;
          fall_n = 1'b1;
        end
      end else if (line_inc >= total_lines) begin
        gate_n = 1'b1;
        rise_n = 1'b1;
        line_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      gate_q <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      line_q <= line_n;
      gate_q <= gate_n;
      rise_q <= rise_n;
      fall_q <= fall_n;
    end
  end

  assign gate_o = gate_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  assert_edges_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_q, fall_q}));

  assert_rise_restarts_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (gate_q && line_q == '0));

  assert_fall_ends_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!gate_q && $past(gate_q)));

endmodule

// File: rtl/ftb_tick_sel.sv
module ftb_tick_sel
  import ftb_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [MODE_W-1:0] mode,
  input  logic              pixel_tick,
  input  logic              line_tick,
  output logic              tick_o
);

  generate
    if (IDX == 2 || IDX >= 4) begin : g_prescaled
      logic [7:0] pre_q, pre_n;
      logic [7:0] lim;
      logic       hit;

      always_comb begin
        lim = 8'd0;
        if (IDX == 2) begin
          lim = mode[MB_DIV8] ? 8'd7 : 8'd0;
        end else begin
          case (mode[MB_PRE_LO +: 2])
            2'd0: lim = 8'd0;
            2'd1: lim = 8'd7;
            2'd2: lim = 8'd15;
            default: lim = 8'd255;
          endcase
        end
      end

      assign hit = (pre_q == lim);

      always_comb begin
        pre_n = pre_q;
        if (clr) begin
          pre_n = '0;
        end else if (run) begin
          pre_n = hit ? 8'd0 : pre_q + 8'd1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_n;
      end

      assign tick_o = run && hit;

      assert_prescale_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= lim);

    end else if (IDX == 0) begin : g_pixel
      assign tick_o = run && (mode[MB_SRC] ? pixel_tick : 1'b1);
    end else begin : g_line
      assign tick_o = run && (mode[MB_SRC] ? line_tick : 1'b1);
    end
  endgenerate

endmodule

// File: rtl/ftb_channel.sv
module ftb_channel
  import ftb_pkg::*;
#(
  parameter int IDX = 0,
  parameter int W   = ch_width(IDX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic             cmp_we,
  input  logic             sts_re,
  input  logic [W-1:0]     wdata,
  input  logic             pixel_tick,
  input  logic             line_tick,
  input  logic             gate_rise,
  input  logic             gate_fall,
  output logic [W-1:0]     count_o,
  output logic [STS_W-1:0] status_o,
  output logic [W-1:0]     compare_o,
  output logic             irq_o
);

  logic [W-1:0]      cnt_q, cnt_n;
  logic [W-1:0]      cmp_q, cmp_n;
  logic [MODE_W-1:0] mode_q, mode_n;
  logic [STS_W-1:0]  sts_q, sts_n;
  logic              run_q, run_n;
  logic              irq_q, irq_n;

  logic              start, halt, tick, adv;
  logic [W:0]        cnt_inc;
  logic [W:0]        tgt_ext;
  logic              tgt_hit, ovf_hit;
  gate_mode_e        gmode;

  assign gmode = gate_mode_e'(mode_q[2:1]);

  // start / halt decision: register write beats gate edges
  always_comb begin
    start  = 1'b0;
    halt   = 1'b0;
    mode_n = mode_q;
    if (mode_we) begin
      mode_n = wdata[MODE_W-1:0];
      halt   = 1'b1;
      if (wdata[MB_RUN] && wdata[2:0] != 3'b111) begin
        start = 1'b1;
        halt  = 1'b0;
      end
    end else if (mode_q[MB_RUN] && mode_q[MB_GATE_EN] && (gate_rise || gate_fall)) begin
      case (gmode)
        GM_RUN_WHILE_HIGH: begin
          start = gate_rise;
          halt  = gate_fall;
        end
        GM_RESTART_ON_RISE: start = gate_rise;
        GM_RUN_WHILE_LOW: begin
          start = gate_fall;
          halt  = gate_rise;
        end
        default: begin
          if (gate_rise) begin
            start = 1'b1;
            mode_n[MB_GATE_EN] = 1'b0;
          end
        end
      endcase
    end
  end

  ftb_tick_sel #(.IDX(IDX)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start || mode_we),
    .run        (run_q),
    .mode       (mode_q),
    .pixel_tick (pixel_tick),
    .line_tick  (line_tick),
    .tick_o     (tick)
  );

  assign adv     = tick && !start && !halt;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign tgt_ext = (cmp_q == '0) ? {1'b1, {W{1'b0}}} : {1'b0, cmp_q};
  assign tgt_hit = adv && (cnt_inc == tgt_ext);
  assign ovf_hit = adv && cnt_inc[W];

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    if (start) begin
      run_n = 1'b1;
      cnt_n = '0;
    end else if (halt) begin
      run_n = 1'b0;
    end else if (adv) begin
      if (ovf_hit || (tgt_hit && mode_q[MB_LOOP])) cnt_n = '0;
      else                                          cnt_n = cnt_inc[W-1:0];
    end
  end

  always_comb begin
    sts_n = sts_re ? '0 : sts_q;
    if (tgt_hit) sts_n[SB_TGT] = 1'b1;
    if (ovf_hit) sts_n[SB_OVF] = 1'b1;
    irq_n = (tgt_hit && mode_q[MB_IRQ_TGT]) || (ovf_hit && mode_q[MB_IRQ_OVF]);
    cmp_n = cmp_we ? wdata : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      mode_q <= '0;
      sts_q  <= '0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      cmp_q  <= cmp_n;
      mode_q <= mode_n;
      sts_q  <= sts_n;
      run_q  <= run_n;
      irq_q  <= irq_n;
    end
  end

  assign count_o   = cnt_q;
  assign status_o  = sts_q;
  assign compare_o = cmp_q;
  assign irq_o     = irq_q;

  assert_hold_when_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !mode_we && !gate_rise && !gate_fall) |=> $stable(cnt_q));

  assert_target_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts_q[SB_TGT]) && mode_q[MB_LOOP]) |-> (cnt_q == '0));

  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[SB_OVF]) |-> (cnt_q == '0));

  assert_irq_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(run_q));

endmodule

// File: rtl/field_timer_bank.sv
module field_timer_bank
  import ftb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pixel_tick,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] visible_lines,
  input  logic [LINE_W-1:0] total_lines,
  output logic [IRQ_W-1:0]  irq_vec
);

  localparam int HI_W = ADDR_W - 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // field gate
  logic gate, gate_rise, gate_fall;

  ftb_field_gate #(.LINE_W(LINE_W)) u_gate (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .line_tick     (line_tick),
    .visible_lines (visible_lines),
    .total_lines   (total_lines),
    .gate_o        (gate),
    .rise_o        (gate_rise),
    .fall_o        (gate_fall)
  );

  // decode
  logic [1:0]        reg_sel;
  logic              sel_ok;
  logic              aligned;
  logic [NUM_CH-1:0] base_hit;
  logic [NUM_CH-1:0] ch_irq;
  logic [DATA_W-1:0] cnt_w [NUM_CH];
  logic [DATA_W-1:0] sts_w [NUM_CH];
  logic [DATA_W-1:0] cmp_w [NUM_CH];

  assign reg_sel = bus_addr[3:2];
  assign sel_ok  = (reg_sel != 2'b11);
  assign aligned = (bus_addr[1:0] == 2'b00);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int CW = ch_width(g);
      localparam logic [15:0] BASE = ch_base(g);

      logic [CW-1:0]    cnt_l, cmp_l;
      logic [STS_W-1:0] sts_l;
      logic             acc;

      assign base_hit[g] = bus_en && aligned &&
                           (bus_addr[ADDR_W-1:4] == HI_W'(BASE[15:4]));
      assign acc = base_hit[g] && sel_ok;

      ftb_channel #(.IDX(g)) u_ch (
        .clk        (clk),
        .rst_n      (rst_i_n),
        .mode_we    (acc && bus_we && reg_sel == SEL_MODE),
        .cmp_we     (acc && bus_we && reg_sel == SEL_CMP),
        .sts_re     (acc && !bus_we && reg_sel == SEL_MODE),
        .wdata      (bus_wdata[CW-1:0]),
        .pixel_tick (pixel_tick),
        .line_tick  (line_tick),
        .gate_rise  (gate_rise),
        .gate_fall  (gate_fall),
        .count_o    (cnt_l),
        .status_o   (sts_l),
        .compare_o  (cmp_l),
        .irq_o      (ch_irq[g])
      );

      assign cnt_w[g] = DATA_W'(cnt_l);
      assign sts_w[g] = DATA_W'(sts_l);
      assign cmp_w[g] = DATA_W'(cmp_l);
    end
  endgenerate

  // read path, registered, updated only on reads
  logic [DATA_W-1:0] rd_mux, rdata_q, rdata_n;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (base_hit[i]) begin
        case (reg_sel)
          SEL_COUNT: rd_mux = cnt_w[i];
          SEL_MODE:  rd_mux = sts_w[i];
          SEL_CMP:   rd_mux = cmp_w[i];
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  assign rdata_n = (bus_en && !bus_we) ? rd_mux : rdata_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rdata_q <= '0;
    else          rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;

  // interrupt vector
  always_comb begin
    irq_vec = '0;
    irq_vec[VBL_BIT] = gate_fall;
    for (int i = 0; i < NUM_CH; i++) begin
      irq_vec[ch_irq_bit(i)] = ch_irq[i];
    end
  end

  assert_single_channel_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(base_hit));

  assert_undecoded_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_en && !bus_we && !(|base_hit && sel_ok)) |=> (bus_rdata == '0));

  assert_vblank_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(gate) |-> irq_vec[VBL_BIT]);

endmodule

// File: tb/field_timer_bank_bench.sv
`timescale 1ns/1ps
module field_timer_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pixel_tick = 1'b0;
  logic        line_tick = 1'b0;
  logic [9:0]  visible_lines = 10'd3;
  logic [9:0]  total_lines = 10'd5;
  logic [16:0] irq_vec;
  logic [16:0] irq_seen = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  field_timer_bank u_field_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pixel_tick(pixel_tick), .line_tick(line_tick),
    .visible_lines(visible_lines), .total_lines(total_lines),
    .irq_vec(irq_vec)
  );

  // collect interrupt pulses away from both clock edges
  always @(posedge clk) begin
    #2 irq_seen = irq_seen | irq_vec;
  end

  function automatic logic [15:0] base_of(input int ch);
    case (ch)
      0: return 16'h1100; 1: return 16'h1110; 2: return 16'h1120;
      3: return 16'h1480; 4: return 16'h1490; default: return 16'h14A0;
    endcase
  endfunction

  function automatic bit decoded(input logic [15:0] a);
    bit hit = 0;
    for (int c = 0; c < 6; c++) if (a[15:4] == base_of(c) >> 4) hit = 1;
    return hit && a[3:2] != 2'b11 && a[1:0] == 2'b00;
  endfunction

  function automatic logic [31:0] width_mask(input int ch, input logic [31:0] d);
    return (ch < 3) ? {16'h0, d[15:0]} : d;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pix(input int n);
    for (int i = 0; i < n; i++) begin
      pixel_tick = 1; @(negedge clk); pixel_tick = 0; @(negedge clk);
    end
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      line_tick = 1; @(negedge clk); line_tick = 0;
    end
  endtask

  // run a channel on its mode for n idle cycles, halt it, return its count
  task automatic run_count(input int ch, input logic [31:0] mode, input int n,
                           output logic [31:0] cnt);
    wr(base_of(ch) + 16'h4, mode);
    idle(n);
    wr(base_of(ch) + 16'h4, 32'h0);
    rd(base_of(ch), cnt);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired got=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, v0, v5;
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);

    idle(3);
    rst_n = 1;
    idle(5);

    // reset state
    check("R2 reset rdata", bus_rdata, 32'h0);
    check("R9 reset irq", {15'h0, irq_vec}, 32'h0);
    rd(16'h1100, d); check("R3 reset count ch0", d, 32'h0);
    rd(16'h1484, d); check("R8 reset status ch3", d, 32'h0);
    rd(16'h14A8, d); check("R2 reset compare ch5", d, 32'h0);

    // R3: system clock counting, halt holds
    run_count(3, 32'h40, 37, d); check("R3 ch3 clock count", d, 32'd37);
    idle(4);
    rd(16'h1480, d); check("R3 halted count held", d, 32'd37);
    wr(16'h1484, 32'h47); idle(6);
    rd(16'h1480, d); check("R3 mode 111 does not start", d, 32'd37);

    // R2: width masking
    wr(16'h1108, 32'h12345678); rd(16'h1108, d); check("R2 ch0 compare 16-bit", d, 32'h5678);
    wr(16'h14A8, 32'h12345678); rd(16'h14A8, d); check("R2 ch5 compare 32-bit", d, 32'h12345678);

    // R2: random compare read-back
    for (int i = 0; i < 20; i++) begin
      int ch;
      logic [31:0] v;
      ch = $urandom % 6;
      v = $urandom;
      wr(base_of(ch) + 16'h8, v);
      rd(base_of(ch) + 16'h8, d);
      check("R2 random compare readback", d, width_mask(ch, v));
    end

    // R1: undecoded accesses
    v0 = 32'h0000BEEF; v5 = 32'hCAFE0001;
    wr(16'h1108, v0); wr(16'h14A8, v5);
    for (int i = 0; i < 30; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (i == 0) a = 16'h110C;
      if (i == 1) a = 16'h1102;
      if (i == 2) a = 16'h14AA;
      if (i == 3) a = 16'h1130;
      if (!decoded(a)) begin
        wr(a, $urandom);
        rd(a, d);
        check("R1 undecoded reads zero", d, 32'h0);
      end
    end
    rd(16'h1108, d); check("R1 undecoded write ignored ch0", d, v0);
    rd(16'h14A8, d); check("R1 undecoded write ignored ch5", d, v5);

    // R4: pixel source on ch0
    wr(16'h1108, 32'h0);
    wr(16'h1104, 32'h140);
    idle(10);
    pix(9);
    lines(0);
    wr(16'h1104, 32'h0);
    rd(16'h1100, d); check("R4 ch0 counts pixel ticks only", d, 32'd9);

    // R5: prescalers
    run_count(2, 32'h040, 20, d);  check("R5 ch2 undivided", d, 32'd20);
    run_count(2, 32'h240, 20, d);  check("R5 ch2 divide by 8", d, 32'd2);
    run_count(4, 32'h2040, 17, d); check("R5 ch4 divide by 8", d, 32'd2);
    run_count(5, 32'h4040, 50, d); check("R5 ch5 divide by 16", d, 32'd3);
    run_count(4, 32'h6040, 600, d); check("R5 ch4 divide by 256", d, 32'd2);

    // R6 / R9: target with loop and interrupt on ch0
    rd(16'h1104, d);
    wr(16'h1108, 32'd5);
    wr(16'h1104, 32'h158);
    irq_seen = '0;
    pix(7);
    wr(16'h1104, 32'h0);
    idle(2);
    rd(16'h1100, d); check("R6 loop count after 7 ticks", d, 32'd2);
    check("R9 target irq on bit 4", {15'h0, irq_seen}, 32'h10);
    rd(16'h1104, d); check("R6 target status", d, 32'h0800);
    rd(16'h1104, d); check("R8 status clears on read", d, 32'h0);

    // R7 / R9: 16-bit wrap on ch0, wrap interrupt only
    wr(16'h1108, 32'd3);
    wr(16'h1104, 32'h160);
    irq_seen = '0;
    pixel_tick = 1;
    idle(65537);
    pixel_tick = 0;
    wr(16'h1104, 32'h0);
    idle(2);
    rd(16'h1100, d); check("R7 count after wrap", d, 32'd1);
    check("R9 wrap irq on bit 4", {15'h0, irq_seen}, 32'h10);
    rd(16'h1104, d); check("R7 wrap and target status", d, 32'h1800);

    // R8: status read in the same cycle as a target event (ch3)
    rd(16'h1484, d);
    wr(16'h1488, 32'd6);
    wr(16'h1484, 32'h40);
    idle(5);
    rd(16'h1484, d);  check("R8 read on event edge sees old status", d, 32'h0);
    rd(16'h1484, d2); check("R8 event survives colliding clear", d2, 32'h0800);
    rd(16'h1484, d);  check("R8 cleared afterwards", d, 32'h0);
    wr(16'h1484, 32'h0);

    // R10 / R11: gate modes (line count 0, gate high here)
    wr(16'h1114, 32'h41);   // ch1 runs while high
    wr(16'h1494, 32'h43);   // ch4 restarts on rise
    wr(16'h14A4, 32'h45);   // ch5 runs while low
    wr(16'h1484, 32'h47);   // ch3 one shot on rise
    irq_seen = '0;
    lines(3);
    idle(2);
    check("R10 vblank irq on bit 0", {15'h0, irq_seen}, 32'h1);
    rd(16'h1110, d); idle(3); rd(16'h1110, d2);
    check("R11 mode 0 halts on fall", d2, d);
    rd(16'h14A0, d); check("R11 mode 2 restarts on fall", d, 32'd6);
    irq_seen = '0;
    lines(2);
    idle(3);
    rd(16'h1480, d); check("R11 one shot starts on rise", d, 32'd2);
    rd(16'h1110, d); check("R11 mode 0 restarts on rise", d, 32'd3);
    rd(16'h1490, d); check("R11 mode 1 restarts on rise", d, 32'd4);
    rd(16'h14A0, d); check("R11 mode 2 halts on rise", d, 32'd9);
    check("R10 no irq on rise", {15'h0, irq_seen}, 32'h0);
    lines(5);
    idle(3);
    rd(16'h1480, d); check("R11 one shot ignores later rise", d, 32'd14);
    rd(16'h1110, d); check("R11 mode 0 second field restart", d, 32'd3);
    for (int c = 0; c < 6; c++) wr(base_of(c) + 16'h4, 32'h0);

    // R4: line source on ch1, pixel ticks ignored
    wr(16'h1114, 32'h140);
    lines(2);
    pix(2);
    lines(2);
    wr(16'h1114, 32'h0);
    rd(16'h1110, d); check("R4 ch1 counts line ticks only", d, 32'd4);

    done = 1;
    summary();
    $finish;
  end

endmodule